// File: doc/BRIEF.md
# Main Clock Failure Supervisor

This block watches the clock currently selected as the main system clock and, if that clock stops, moves the system onto a safe startup source. A flop in the monitored clock's domain toggles on every monitored edge. The block resynchronises that toggle into a free-running reference clock and counts reference cycles between observed edges. When the count reaches a programmable threshold with no edge, a failure is declared. Software can also inject a failure through a test bit, which behaves exactly like a real loss of clock.

On a failure the source-select code reverts to the startup code supplied by a configuration fuse input. The prescaler value reloads to zero and the clock-out enable drops. A failure flag is set. Depending on an interrupt-type bit, the failure raises either a normal interrupt, cleared by writing one to the flag, or a non-maskable interrupt that stays pending until reset. Control registers are write-protected: a key write opens a short window in which one protected write is accepted. The glitch-free multiplexer and the oscillators sit outside this block. They appear only as a select code, a prescaler value and a readiness input.

Top module: `cfd_top`

## Requirements
- R1: Register map (byte-wide, `bus_addr`): 0 source (bits 1:0 source code, bit 4 clock-out enable), 1 prescaler, 2 detector (bit 0 enable, bit 1 test), 3 interrupt (bit 0 enable, bit 1 type, 1 = non-maskable), 4 flags (bit 0 failure flag, bit 1 non-maskable pending, read-only), 5 status (bit 0 switch busy, bit 1 external oscillator stable), 6 key, 7 timeout threshold. On a failure `src_sel_o` takes the value of `fuse_src_i`.
- R2: On a failure the prescaler register reloads to 0.
- R3: On a failure `clkout_en_o` clears and stays clear until software writes bit 4 of the source register again.
- R4: With interrupt enable set and type 0, a failure raises `irq_o` (flag AND enable); with type 1 it raises `nmi_o` and not `irq_o`.
- R5: `nmi_o` stays high once set; writing one to the flag does not clear it; only reset does.
- R6: Setting the test bit while the detector is enabled causes a failure identical to a real one; the test bit then reads back as 0.
- R7: A failure sets the flag bit; writing 1 to flag bit 0 clears it and writing 0 leaves it set.
- R8: Addresses 0, 1, 2, 3 and 7 are protected. A protected write takes effect only if the key 0xC5 was written to address 6 and the protected write comes in one of the next four cycles; the window closes after one protected write. Other protected writes are ignored.
- R9: After any change of the source code, status bit 0 reads 1 for SW_CYC (default 4) cycles, then 0. Status bit 1 follows `xosc_ready_i`.
- R10: With the detector enabled, monitored toggles arriving at most every THRESH reference cycles never cause a failure. A gap of THRESH+3 or more cycles causes one. With the detector disabled, no failure occurs.
- R11: After reset: prescaler 0, clock-out off, detector and interrupts off, flags clear, threshold 16, and `src_sel_o` equals `fuse_src_i` from the second cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mon_tog_i | input | 1 | Toggle driven from the monitored clock domain |
| xosc_ready_i | input | 1 | External oscillator stable indication |
| fuse_src_i | input | 2 | Startup source code from configuration fuse |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| src_sel_o | output | 2 | Selected main clock source code |
| presc_o | output | 8 | Prescaler control value |
| clkout_en_o | output | 1 | Clock-out pin enable |
| irq_o | output | 1 | Normal interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
The bench sweeps the idle gap between the key write and a protected write across the window edge. A window that is one cycle short or long would accept or drop a write at the boundary. It sweeps monitored toggle periods on both sides of several thresholds, so an off-by-one or a counter that never clears shows up as a spurious or missing failure. Injected failures are checked for the full fallback set: source code, prescaler, clock-out and flag. A design that forgot one of these would leave stale clock settings in place. The non-maskable pending state is checked to survive a flag clear. A design that tied it to the flag would let a handler silently return.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
    localparam int DATA_W = 8;
    localparam int SRC_W  = 2;
    localparam int WIN_W  = 3;

    localparam logic [2:0] A_SRC    = 3'd0;
    localparam logic [2:0] A_PRESC  = 3'd1;
    localparam logic [2:0] A_DET    = 3'd2;
    localparam logic [2:0] A_INT    = 3'd3;
    localparam logic [2:0] A_FLAG   = 3'd4;
    localparam logic [2:0] A_STAT   = 3'd5;
    localparam logic [2:0] A_KEY    = 3'd6;
    localparam logic [2:0] A_THRESH = 3'd7;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic              clkout;
        logic [DATA_W-1:0] presc;
        logic              det_en;
        logic              test;
        logic              int_en;
        logic              nmi_type;
        logic              flag;
        logic              nmi_pend;
        logic [DATA_W-1:0] thresh;
        logic [WIN_W-1:0]  win;
        logic              boot;
    } cfd_state_t;
endpackage

// File: rtl/cfd_edge_sync.sv
module cfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tog_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q, sync_d;
    logic              prev_q, prev_d;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], tog_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/cfd_timeout.sv
module cfd_timeout #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             timeout_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || edge_i || clr_i)
            cnt_d = '0;
        else if (cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign timeout_o = en_i && !edge_i && (cnt_q >= thresh_i);

    // R10: an observed monitored edge restarts the gap count
    p_edge_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_i |=> (cnt_q == '0));
endmodule

// File: rtl/cfd_switch_timer.sv
module cfd_switch_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)           cnt_d = LOAD;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R9: a source change always shows busy in the following cycle
    p_busy_after_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o);
endmodule

// File: rtl/cfd_top.sv
module cfd_top
    import cfd_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_VAL    = 8'hC5,
    parameter int                KEY_WIN    = 4,
    parameter int                SW_CYC     = 4,
    parameter int                DEF_THRESH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mon_tog_i,
    input  logic              xosc_ready_i,
    input  logic [SRC_W-1:0]  fuse_src_i,
    input  logic              bus_we_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [SRC_W-1:0]  src_sel_o,
    output logic [DATA_W-1:0] presc_o,
    output logic              clkout_en_o,
    output logic              irq_o,
    output logic              nmi_o
);
    localparam logic [WIN_W-1:0]  WIN_LOAD   = WIN_W'(KEY_WIN);
    localparam logic [DATA_W-1:0] THR_RESET  = DATA_W'(DEF_THRESH);

    cfd_state_t s_q, s_d;
    logic mon_edge, timeout, busy, fail, key_hit, prot_sel, prot_ok, src_change;

    cfd_edge_sync #(.STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tog_i  (mon_tog_i),
        .edge_o (mon_edge)
    );

    cfd_timeout #(.CNT_W(DATA_W)) u_tmo (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (s_q.det_en & ~busy),
        .clr_i     (fail),
        .edge_i    (mon_edge),
        .thresh_i  (s_q.thresh),
        .timeout_o (timeout)
    );

    cfd_switch_timer #(.CYCLES(SW_CYC)) u_sw (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (src_change),
        .busy_o  (busy)
    );

    assign fail       = s_q.det_en & (s_q.test | timeout);
    assign key_hit    = bus_we_i && (bus_addr_i == A_KEY) && (bus_wdata_i == KEY_VAL);
    assign prot_sel   = (bus_addr_i == A_SRC) || (bus_addr_i == A_PRESC) ||
                        (bus_addr_i == A_DET) || (bus_addr_i == A_INT) ||
                        (bus_addr_i == A_THRESH);
    assign prot_ok    = bus_we_i && prot_sel && (s_q.win != '0);
    assign src_change = (s_d.src != s_q.src);

    always_comb begin
        s_d = s_q;
        if (s_q.win != '0) s_d.win = s_q.win - 1'b1;
        if (s_q.boot) begin
            s_d.src  = fuse_src_i;
            s_d.boot = 1'b0;
        end
        if (key_hit) begin
            s_d.win = WIN_LOAD;
        end else if (prot_ok) begin
            s_d.win = '0;
            case (bus_addr_i)
                A_SRC: begin
                    s_d.src    = bus_wdata_i[SRC_W-1:0];
                    s_d.clkout = bus_wdata_i[4];
                end
                A_PRESC: s_d.presc = bus_wdata_i;
                A_DET: begin
                    s_d.det_en = bus_wdata_i[0];
                    s_d.test   = bus_wdata_i[1];
                end
                A_INT: begin
                    s_d.int_en   = bus_wdata_i[0];
                    s_d.nmi_type = bus_wdata_i[1];
                end
                default: s_d.thresh = bus_wdata_i;
            endcase
        end
        if (bus_we_i && (bus_addr_i == A_FLAG) && bus_wdata_i[0])
            s_d.flag = 1'b0;
        if (fail) begin
            s_d.src    = fuse_src_i;
            s_d.presc  = '0;
            s_d.clkout = 1'b0;
            s_d.test   = 1'b0;
            s_d.flag   = 1'b1;
            if (s_q.int_en && s_q.nmi_type) s_d.nmi_pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q        <= '0;
            s_q.thresh <= THR_RESET;
            s_q.boot   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_SRC:   begin
                bus_rdata_o[SRC_W-1:0] = s_q.src;
                bus_rdata_o[4]         = s_q.clkout;
            end
            A_PRESC: bus_rdata_o = s_q.presc;
            A_DET:   bus_rdata_o[1:0] = {s_q.test, s_q.det_en};
            A_INT:   bus_rdata_o[1:0] = {s_q.nmi_type, s_q.int_en};
            A_FLAG:  bus_rdata_o[1:0] = {s_q.nmi_pend, s_q.flag};
            A_STAT:  bus_rdata_o[1:0] = {xosc_ready_i, busy};
            A_THRESH: bus_rdata_o = s_q.thresh;
            default: bus_rdata_o = '0;
        endcase
    end

    assign src_sel_o   = s_q.src;
    assign presc_o     = s_q.presc;
    assign clkout_en_o = s_q.clkout;
    assign irq_o       = s_q.flag & s_q.int_en & ~s_q.nmi_type;
    assign nmi_o       = s_q.nmi_pend;

    p_fallback_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail |=> (src_sel_o == $past(fuse_src_i)));
    p_presc_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail |=> (presc_o == '0));
    p_clkout_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail |=> !clkout_en_o);
    p_nmi_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_o |=> nmi_o);
    p_test_selfclear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail |=> !s_q.test);
    p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail |=> s_q.flag);
endmodule

// File: tb/cfd_top_tb.sv
module cfd_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_tog = 1'b0;
    logic       xosc_rdy = 1'b0;
    logic [1:0] fuse = 2'd3;
    logic       we = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] src;
    logic [7:0] presc;
    logic       clkout, irq, nmi;

    int checks = 0;
    int fails  = 0;
    int gap    = 0;
    int gcnt   = 0;
    int cyc    = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    cfd_top u_dut (
        .clk_i(clk), .rst_ni(rst_n), .mon_tog_i(mon_tog), .xosc_ready_i(xosc_rdy),
        .fuse_src_i(fuse), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .src_sel_o(src), .presc_o(presc), .clkout_en_o(clkout),
        .irq_o(irq), .nmi_o(nmi)
    );

    // monitored toggle: changes every 'gap' reference cycles, frozen when gap == 0
    always @(negedge clk) begin
        if (gap != 0) begin
            gcnt <= gcnt + 1;
            if (gcnt + 1 >= gap) begin
                gcnt    <= 0;
                mon_tog <= ~mon_tog;
            end
        end else begin
            gcnt <= 0;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic pwr(input logic [2:0] a, input logic [7:0] d);
        wr(3'd6, 8'hC5);
        wr(a, d);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(3);

        // R11 reset state
        chk("R11 src=fuse", src, 3);
        chk("R11 presc", presc, 0);
        chk("R11 clkout", clkout, 0);
        chk("R11 irq", irq, 0);
        chk("R11 nmi", nmi, 0);
        rd(3'd7, v); chk("R11 thresh", v, 16);
        rd(3'd4, v); chk("R11 flags", v, 0);
        idle(8);

        // R8 window sweep: idle n cycles between key and protected write
        for (int n = 0; n <= 6; n++) begin
            wr(3'd1, 8'h00); // unprotected attempt, should be ignored anyway
            wr(3'd6, 8'hC5);
            idle(n);
            wr(3'd1, 8'(n * 3 + 1));
            rd(3'd1, v);
            chk("R8 window", v, (n <= 3) ? n * 3 + 1 : ((n == 4) ? 10 : 10));
            idle(6);
        end
        wr(3'd1, 8'h55);
        rd(3'd1, v); chk("R8 no key", v, 10);
        pwr(3'd1, 8'h11);
        wr(3'd1, 8'h22);
        rd(3'd1, v); chk("R8 one write per key", v, 8'h11);

        // R9 busy on source change, xosc mirror
        xosc_rdy = 1'b1;
        pwr(3'd0, 8'h11);
        rd(3'd5, v); chk("R9 busy high", v, 3);
        idle(4);
        rd(3'd5, v); chk("R9 busy low", v, 2);
        chk("R9 src", src, 1);
        chk("R3 clkout set", clkout, 1);

        // R6/R1/R2/R3/R7/R4 test-bit failure with normal interrupt
        pwr(3'd1, 8'h37);
        pwr(3'd3, 8'h01);
        pwr(3'd2, 8'h03);
        idle(3);
        chk("R1 fallback", src, 3);
        chk("R2 presc reload", presc, 0);
        chk("R3 clkout off", clkout, 0);
        rd(3'd4, v); chk("R7 flag set", v, 1);
        rd(3'd2, v); chk("R6 test cleared", v, 1);
        chk("R4 irq", irq, 1);
        chk("R4 no nmi", nmi, 0);
        wr(3'd4, 8'h00);
        rd(3'd4, v); chk("R7 write 0 keeps", v, 1);
        wr(3'd4, 8'h01);
        rd(3'd4, v); chk("R7 w1c", v, 0);
        chk("R4 irq cleared", irq, 0);
        idle(4);
        chk("R3 clkout stays off", clkout, 0);
        pwr(3'd0, 8'h12);
        chk("R3 clkout rewritten", clkout, 1);

        // R4/R5 non-maskable path with different fuse code
        fuse = 2'd1;
        idle(6);
        pwr(3'd3, 8'h03);
        pwr(3'd2, 8'h03);
        idle(3);
        chk("R1 fallback fuse1", src, 1);
        chk("R4 nmi", nmi, 1);
        chk("R4 irq off for nmi", irq, 0);
        wr(3'd4, 8'h01);
        idle(2);
        chk("R5 nmi sticky", nmi, 1);
        rd(3'd4, v); chk("R5 pending bit", v, 2);
        pwr(3'd2, 8'h00);
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(3);
        chk("R5 reset clears nmi", nmi, 0);

        // R10 timeout sweep over thresholds and toggle gaps
        for (int t = 4; t <= 8; t += 2) begin
            for (int g = 2; g <= t + 5; g++) begin
                if (g == t + 1 || g == t + 2) continue;
                gap = g;
                pwr(3'd7, 8'(t));
                wr(3'd4, 8'h01);
                idle(12);
                pwr(3'd2, 8'h01);
                idle(6 * g + 20);
                rd(3'd4, v);
                chk($sformatf("R10 t=%0d g=%0d", t, g), v[0], (g >= t + 3) ? 1 : 0);
                pwr(3'd2, 8'h00);
                idle(8);
            end
        end
        // R10 detector disabled: stopped clock, no failure
        gap = 0;
        wr(3'd4, 8'h01);
        idle(80);
        rd(3'd4, v); chk("R10 disabled no fail", v[0], 0);
        // R10 stopped clock with detector on: failure
        pwr(3'd2, 8'h01);
        idle(30);
        rd(3'd4, v); chk("R10 stopped clock fails", v[0], 1);

        finish_run();
    end
endmodule